// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table, each entry made of 8-bit red, green and blue parts. Software fills it through a 16-byte register window on a plain 32-bit bus. One register chooses which entry will be written next. A second register accepts the colour parts one after another, in the order red, green, blue. A hidden two-bit step counter remembers which part comes next. After the blue part, the chosen entry advances by one and wraps from 255 to 0. This lets a whole table be streamed as a run of data writes after a single index write.

A pixel pipeline looks colours up through a separate read port with one cycle of latency. The block also emits a one-cycle strobe, carrying the entry number, each time a part of an entry changes. Downstream logic can use it to refresh cached copies of that entry. Reset puts the table into a known state: black everywhere except the last entry, which is white.

The bus request side has no back-pressure. Every beat with `bus_valid` high is taken in the cycle it is presented, so there is no ready signal. A read request is answered by exactly one `bus_rsp_valid` pulse on the next cycle. The lookup port is likewise never stalled: a request on `lut_rd_en` is always followed one cycle later by `lut_rd_valid`.

Top module: `clut_loader`

## Requirements
- R1: After reset, every entry reads as 0x000000 except entry 255, which reads 0xFFFFFF. The entry pointer and the step counter start at 0 and red, so the first data write goes to red of entry 0.
- R2: A full-width write (byte enables 4'hF) to offset 0x0 loads the entry pointer from write-data bits 31:24. It also returns the step counter to red.
- R3: A full-width write to offset 0x4 stores write-data bits 31:24 into one part of the pointed entry, chosen by the step counter in the order red, green, blue. An entry reads as {red[23:16], green[15:8], blue[7:0]}.
- R4: After a blue part is stored, the entry pointer increases by one modulo 256 (255 goes to 0) and the step counter returns to red.
- R5: An offset-0x0 write made partway through a red/green/blue sequence restarts the sequence at red, at the new entry.
- R6: A write whose byte enables are not 4'hF changes no entry, no pointer and no step counter, and raises no update strobe.
- R7: Writes to offsets other than 0x0 and 0x4 (for example 0x8 and 0xC) change no state and raise no update strobe.
- R8: Each bus read is answered one cycle later by `bus_rsp_valid` with `bus_rdata` equal to zero. A read changes no state.
- R9: A lookup request on `lut_rd_en` with entry `lut_rd_idx` yields `lut_rd_valid` and that entry's colour on `lut_rd_data` in the next cycle.
- R10: When a lookup and a part write hit the same entry in one cycle, the lookup returns the colour from before the write.
- R11: Each stored part raises `upd_valid` for exactly one cycle, in the cycle after the write, with `upd_idx` equal to the entry written. Other entries stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_valid | input | 1 | Bus request present; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_be | input | 4 | Byte enables; only 4'hF writes take effect |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the payload |
| bus_rsp_valid | output | 1 | Read response, one cycle after a read |
| bus_rdata | output | 32 | Read data, always zero |
| lut_rd_en | input | 1 | Lookup request |
| lut_rd_idx | input | 8 | Entry to look up |
| lut_rd_valid | output | 1 | Lookup result valid |
| lut_rd_data | output | 24 | Looked-up colour {R,G,B} |
| upd_valid | output | 1 | One-cycle strobe for a changed entry |
| upd_idx | output | 8 | Entry that changed |

## Verification
The hardest condition to reach is a lookup and a part write to the same entry in the same cycle. The stimulus gets there with a combined driver task that sets the data write and the lookup on the same clock edge. It does this at entries whose old and new colours differ, so the earlier colour can be told apart from the later one. A second hard spot is the pointer wrapping from 255 to 0 partway through a stream of writes. The stimulus aims the pointer at 255, completes one triple, and then confirms that the next red lands in entry 0. Rejected partial-width writes are confirmed in two ways: an unexpected update strobe counts as a failure, and the write that follows must still land on the expected part.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // Component step counter (2 bits wide; the value 3 is never produced in normal use)
  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2,
    STEP_BAD = 2'd3
  } step_e;

  localparam int unsigned OFF_POINTER = 0;
  localparam int unsigned OFF_COLOUR  = 4;
  localparam int unsigned NUM_PARTS   = 3;
endpackage

// File: rtl/clut_regif.sv
module clut_regif
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rsp_valid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_fire,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [1:0]        wr_part,
  output logic [COMP_W-1:0] wr_val
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic             full_wr;
  logic             hit_ptr;
  logic             hit_col;
  logic [IDX_W-1:0] ptr_q;
  step_e            step_q;

  assign full_wr = bus_valid && bus_write && (bus_be == {BE_W{1'b1}});
  assign hit_ptr = full_wr && (bus_addr == ADDR_W'(OFF_POINTER));
  assign hit_col = full_wr && (bus_addr == ADDR_W'(OFF_COLOUR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= STEP_RED;
    end else if (hit_ptr) begin
      ptr_q  <= bus_wdata[DATA_W-1 -: IDX_W];
      step_q <= STEP_RED;
    end else if (hit_col) begin
      unique case (step_q)
        STEP_RED: step_q <= STEP_GRN;
        STEP_GRN: step_q <= STEP_BLU;
        STEP_BLU: begin
          step_q <= STEP_RED;
          ptr_q  <= ptr_q + 1'b1;
        end
        default:  step_q <= STEP_RED;
      endcase
    end
  end

  // A stray step value recovers to red without storing anything
  assign wr_fire = hit_col && (step_q != STEP_BAD);
  assign wr_idx  = ptr_q;
  assign wr_part = step_q;
  assign wr_val  = bus_wdata[DATA_W-1 -: COMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rsp_valid <= 1'b0;
    else        bus_rsp_valid <= bus_valid && !bus_write;
  end

  assign bus_rdata = '0;
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_fire,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [1:0]                wr_part,
  input  logic [COMP_W-1:0]         wr_val,
  input  logic                      rd_en,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic                      rd_valid,
  output logic [NUM_PARTS*COMP_W-1:0] rd_data,
  output logic                      upd_valid,
  output logic [IDX_W-1:0]          upd_idx
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned PIX_W   = NUM_PARTS * COMP_W;

  logic [NUM_PARTS-1:0][COMP_W-1:0] tbl [ENTRIES];

  // Lane 2 holds red, lane 0 holds blue
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [PIX_W-1:0] RST_VAL = (e == ENTRIES - 1) ? {PIX_W{1'b1}} : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[e] <= RST_VAL;
      end else if (wr_fire && (wr_idx == IDX_W'(e))) begin
        unique case (wr_part)
          2'd0:    tbl[e][2] <= wr_val;
          2'd1:    tbl[e][1] <= wr_val;
          default: tbl[e][0] <= wr_val;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      upd_valid <= 1'b0;
      upd_idx   <= '0;
    end else begin
      rd_valid  <= rd_en;
      if (rd_en) rd_data <= tbl[rd_idx];
      upd_valid <= wr_fire;
      if (wr_fire) upd_idx <= wr_idx;
    end
  end
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W/8-1:0]         bus_be,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic                        bus_rsp_valid,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        lut_rd_en,
  input  logic [IDX_W-1:0]            lut_rd_idx,
  output logic                        lut_rd_valid,
  output logic [NUM_PARTS*COMP_W-1:0] lut_rd_data,
  output logic                        upd_valid,
  output logic [IDX_W-1:0]            upd_idx
);
  logic              wr_fire;
  logic [IDX_W-1:0]  wr_idx;
  logic [1:0]        wr_part;
  logic [COMP_W-1:0] wr_val;

  clut_regif #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regif_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_part(wr_part), .wr_val(wr_val)
  );

  clut_store #(
    .IDX_W(IDX_W), .COMP_W(COMP_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_part(wr_part), .wr_val(wr_val),
    .rd_en(lut_rd_en), .rd_idx(lut_rd_idx),
    .rd_valid(lut_rd_valid), .rd_data(lut_rd_data),
    .upd_valid(upd_valid), .upd_idx(upd_idx)
  );
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic                bus_rsp_valid,
  input logic                lut_rd_en,
  input logic                lut_rd_valid,
  input logic                upd_valid,
  input logic [IDX_W-1:0]    upd_idx
);
  localparam int unsigned BE_W = DATA_W / 8;

  p_rsp_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rsp_valid);

  p_rsp_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid |-> $past(bus_valid && !bus_write));

  p_lookup_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lut_rd_en |=> lut_rd_valid);

  p_upd_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(bus_valid && bus_write && bus_be == {BE_W{1'b1}}
                        && bus_addr == ADDR_W'(4)));

  p_partial_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_be != {BE_W{1'b1}}) |=> !upd_valid);

  p_other_offset_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr != ADDR_W'(4)) |=> !upd_valid);

  p_upd_idx_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !$isunknown(upd_idx));
endmodule

bind clut_loader clut_loader_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_rsp_valid(bus_rsp_valid),
  .lut_rd_en(lut_rd_en), .lut_rd_valid(lut_rd_valid),
  .upd_valid(upd_valid), .upd_idx(upd_idx)
);

// File: tb/clut_loader_tb_top.sv
module clut_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rsp_valid;
  logic [31:0] bus_rdata;
  logic        lut_rd_en = 1'b0;
  logic [7:0]  lut_rd_idx = '0;
  logic        lut_rd_valid;
  logic [23:0] lut_rd_data;
  logic        upd_valid;
  logic [7:0]  upd_idx;

  always #2.5 clk = ~clk;

  clut_loader dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata),
    .lut_rd_en(lut_rd_en), .lut_rd_idx(lut_rd_idx),
    .lut_rd_valid(lut_rd_valid), .lut_rd_data(lut_rd_data),
    .upd_valid(upd_valid), .upd_idx(upd_idx)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  logic [23:0] model [256];
  int m_ptr = 0;
  int m_step = 0;

  logic [23:0] q_pix [$];
  string       q_pix_tag [$];
  int          q_upd [$];
  string       q_upd_tag [$];
  int          q_rsp = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference behaviour of a bus write, from the requirements
  task automatic apply_model(logic [3:0] a, logic [31:0] d, logic [3:0] be, string tag);
    if (be != 4'hF) return;
    if (a == 4'h0) begin
      m_ptr = int'(d[31:24]);
      m_step = 0;
    end else if (a == 4'h4) begin
      q_upd.push_back(m_ptr);
      q_upd_tag.push_back(tag);
      case (m_step)
        0: model[m_ptr][23:16] = d[31:24];
        1: model[m_ptr][15:8]  = d[31:24];
        default: model[m_ptr][7:0] = d[31:24];
      endcase
      if (m_step == 2) begin
        m_step = 0;
        m_ptr = (m_ptr + 1) % 256;
      end else begin
        m_step++;
      end
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    apply_model(a, d, be, tag);
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic put_col(logic [7:0] v, string tag);
    bus_wr(4'h4, {v, 24'h5A5A5A}, 4'hF, tag);
  endtask

  task automatic bus_rd(logic [3:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
    q_rsp++;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic lut_rd(logic [7:0] i, string tag);
    @(negedge clk);
    lut_rd_en = 1'b1; lut_rd_idx = i;
    q_pix.push_back(model[i]);
    q_pix_tag.push_back(tag);
    @(posedge clk); #1;
    lut_rd_en = 1'b0;
  endtask

  // Colour write and lookup in the same cycle
  task automatic col_and_rd(logic [7:0] v, logic [7:0] i, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'h4; bus_be = 4'hF;
    bus_wdata = {v, 24'h0};
    lut_rd_en = 1'b1; lut_rd_idx = i;
    q_pix.push_back(model[i]);
    q_pix_tag.push_back(tag);
    apply_model(4'h4, {v, 24'h0}, 4'hF, tag);
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; lut_rd_en = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      if (lut_rd_valid) begin
        if (q_pix.size() == 0) check(1'b0, "R9 unexpected lookup result", 32'(lut_rd_data), 32'h0);
        else begin
          logic [23:0] e;
          string t;
          e = q_pix.pop_front();
          t = q_pix_tag.pop_front();
          check(lut_rd_data == e, t, 32'(lut_rd_data), 32'(e));
        end
      end
      if (upd_valid) begin
        if (q_upd.size() == 0) check(1'b0, "R6/R7 unexpected update strobe", 32'(upd_idx), 32'h0);
        else begin
          int e;
          string t;
          e = q_upd.pop_front();
          t = q_upd_tag.pop_front();
          check(int'(upd_idx) == e, {t, " R11 strobe index"}, 32'(upd_idx), 32'(e));
        end
      end
      if (bus_rsp_valid) begin
        if (q_rsp == 0) check(1'b0, "R8 unexpected response", bus_rdata, 32'h0);
        else begin
          q_rsp--;
          check(bus_rdata == 32'h0, "R8 read data zero", bus_rdata, 32'h0);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 24'h0;
    model[255] = 24'hFFFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!upd_valid && !lut_rd_valid && !bus_rsp_valid, "R1 outputs idle after reset",
          {29'h0, upd_valid, lut_rd_valid, bus_rsp_valid}, 32'h0);
    running = 1'b1;

    // R1: reset contents
    lut_rd(8'd0, "R1 entry 0");
    lut_rd(8'd100, "R1 entry 100");
    lut_rd(8'd254, "R1 entry 254");
    lut_rd(8'd255, "R1 entry 255 white");

    // R1/R3: first triple lands in entry 0
    put_col(8'h11, "R3 red");
    put_col(8'h22, "R3 green");
    put_col(8'h33, "R3 blue");
    lut_rd(8'd0, "R3 entry 0 triple");
    // R4: pointer moved to entry 1
    put_col(8'h44, "R4 next red");
    lut_rd(8'd1, "R4 entry 1 red after increment");
    lut_rd(8'd2, "R11 neighbour untouched");

    // R2/R5: pointer write restarts sequence
    bus_wr(4'h0, 32'h10_00_00_00, 4'hF, "R2");
    put_col(8'hA1, "R2 red");
    put_col(8'hA2, "R2 green");
    bus_wr(4'h0, 32'h20_FF_FF_FF, 4'hF, "R5");
    put_col(8'hB1, "R5 red after restart");
    lut_rd(8'h10, "R5 entry 0x10 partial");
    lut_rd(8'h20, "R5 entry 0x20 red");

    // R4: wrap 255 -> 0
    bus_wr(4'h0, 32'hFF_00_00_00, 4'hF, "R4");
    put_col(8'h01, "R4 red 255");
    put_col(8'h02, "R4 green 255");
    put_col(8'h03, "R4 blue 255");
    put_col(8'h77, "R4 red after wrap");
    lut_rd(8'd255, "R4 entry 255");
    lut_rd(8'd0, "R4 entry 0 after wrap");

    // R6: partial byte enables ignored
    bus_wr(4'h0, 32'h40_00_00_00, 4'hF, "R6");
    bus_wr(4'h4, 32'hEE_00_00_00, 4'h7, "R6 partial colour");
    bus_wr(4'h0, 32'h50_00_00_00, 4'h8, "R6 partial pointer");
    put_col(8'hC1, "R6 red still first");
    lut_rd(8'h40, "R6 entry 0x40");
    lut_rd(8'h50, "R6 entry 0x50 untouched");

    // R7: other offsets ignored
    bus_wr(4'h8, 32'h99_00_00_00, 4'hF, "R7 off 8");
    bus_wr(4'hC, 32'h98_00_00_00, 4'hF, "R7 off C");
    put_col(8'hC2, "R7 green still next");
    lut_rd(8'h40, "R7 entry 0x40 red+green");

    // R8: reads return zero, no state change
    bus_rd(4'h0);
    bus_rd(4'h4);
    bus_rd(4'hC);
    put_col(8'hC3, "R8 blue still next");
    lut_rd(8'h40, "R8 entry 0x40 full");

    // R10: same-cycle write and lookup
    bus_wr(4'h0, 32'h60_00_00_00, 4'hF, "R10");
    lut_rd(8'h60, "R10 before");
    col_and_rd(8'hD1, 8'h60, "R10 old red returned");
    col_and_rd(8'hD2, 8'h60, "R10 old green returned");
    lut_rd(8'h60, "R10 after");

    repeat (4) @(negedge clk);
    check(q_pix.size() == 0, "R9 all lookups answered", 32'(q_pix.size()), 32'h0);
    check(q_upd.size() == 0, "R11 all strobes seen", 32'(q_upd.size()), 32'h0);
    check(q_rsp == 0, "R8 all reads answered", 32'(q_rsp), 32'h0);
    finish_run();
  end
endmodule